// File: doc/BRIEF.md
# Shared DRAM Access Arbiter

This block decides which requestor owns a single external DRAM in a LAN/WAN bridge. Eleven external request lines come from the LAN and WAN frame ports, the address filtering engines and the processor. Three internal housekeeping requestors are raised by the block itself: a one-time memory initialization after reset, a periodic refresh and a periodic source-address database aging pass. The arbiter never sequences DRAM commands. It only picks an owner, pulses that owner's grant for one cycle and then waits for the memory sequencer to pulse `done_i`.

Requests are ranked in nine fixed classes. Four of these classes hold two requestors each. Within such a pair the grant alternates round-robin. The processor classes have no protection against starvation. Refresh ranks below all external traffic. Aging ranks lowest, and it may win only while the LAN side reports an interframe gap.

Top module: `dram_arbiter`

## Requirements
- R1: After reset the first grant is `hk_gnt_o[0]` (initialization), issued on the first clock edge after reset release. No other grant is issued until `done_i` ends that initialization ownership.
- R2: At most one grant bit across `gnt_o` and `hk_gnt_o` is high in any cycle, and each grant lasts one cycle. `busy_o` is high from the grant until the edge that samples `done_i`. A new grant can appear at the earliest on the edge after the one that cleared `busy_o`. After reset all grant outputs and `busy_o` are 0.
- R3: The classes rank as follows, from highest to lowest. LAN frame is `req_i[1:0]` (bit 0 receive, bit 1 transmit). WAN frame is `req_i[3:2]`. LAN destination lookup is `req_i[4]`. Source-address maintenance is `req_i[5]`. WAN destination lookup is `req_i[6]`. Processor frame is `req_i[8:7]`. Processor DMA is `req_i[10:9]` (bit 9 write, bit 10 read). Refresh (`hk_gnt_o[1]`) comes next, and aging (`hk_gnt_o[2]`) is last. `gnt_o[i]` answers `req_i[i]`.
- R4: Within each two-member class, the lower bit wins after reset when both members request. After a grant inside the class, the other member is favored. The preference changes only when that class receives a grant.
- R5: Processor frame and processor DMA requests wait without limit while any higher class keeps requesting.
- R6: The refresh timer raises a pending refresh every `refresh_period_i` cycles. It counts from the release of the initialization grant. A period of 0 stops refresh requests.
- R7: Only one refresh can be pending. An expiry that occurs while a refresh is already pending and is not being granted increments `refresh_miss_o`, which saturates at its maximum. An expiry at the maximum sets `refresh_ovf_o`, which stays set until reset.
- R8: An aging request is raised every AGE_PERIOD cycles after initialization. It is granted only on an edge where `lan_gap_i` was high in the preceding cycle.
- R9: A `done_i` pulse while the arbiter is idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 11 | External request lines, mapping in R3 |
| done_i | input | 1 | Owner has finished its memory access |
| lan_gap_i | input | 1 | LAN link is in its interframe gap |
| refresh_period_i | input | RCNT_W | Refresh interval in cycles, 0 stops refresh |
| gnt_o | output | 11 | One-cycle grant per external request line |
| hk_gnt_o | output | 3 | One-cycle housekeeping grants: bit 0 init, bit 1 refresh, bit 2 aging |
| busy_o | output | 1 | Memory is owned |
| refresh_miss_o | output | MISS_W | Saturating count of lost refresh expiries |
| refresh_ovf_o | output | 1 | Sticky flag for an expiry lost at full count |

## Verification
A grant appears on the first edge that samples an idle arbiter with a pending request. `busy_o` drops on the edge that samples `done_i`, so the next grant comes one edge after that. A refresh first becomes pending `refresh_period_i` edges after the edge that ends initialization. The miss counter and the overflow flag change on the edge that samples an expiry. The bench drives inputs and samples outputs at the falling edge. Each cycle it advances a requirement-level model by exactly one rising edge and compares every output against it. The directed cases then state literal values at the cycle where each result falls due.

// File: rtl/dram_arb_pkg.sv
package dram_arb_pkg;
    localparam int NUM_EXT  = 11;
    localparam int NUM_CLS  = 9;
    localparam int NUM_HK   = 3;
    localparam int NUM_PAIR = 4;

    // housekeeping grant positions
    localparam int HK_INIT    = 0;
    localparam int HK_REFRESH = 1;
    localparam int HK_AGING   = 2;

    // class ranking, index 0 is highest (R3)
    typedef enum logic [3:0] {
        CLS_LAN_FRM = 4'd0,
        CLS_WAN_FRM = 4'd1,
        CLS_LAN_DA  = 4'd2,
        CLS_SA_MNT  = 4'd3,
        CLS_WAN_DA  = 4'd4,
        CLS_CPU_FRM = 4'd5,
        CLS_CPU_DMA = 4'd6,
        CLS_REFRESH = 4'd7,
        CLS_AGING   = 4'd8
    } arb_cls_e;

    // paired classes: lowest request bit and class rank
    localparam int PAIR_BASE [NUM_PAIR] = '{0, 2, 7, 9};
    localparam int PAIR_CLS  [NUM_PAIR] = '{0, 1, 5, 6};
endpackage

// File: rtl/dram_arb_pair.sv
module dram_arb_pair (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req_i,
    input  logic       take_i,
    output logic [1:0] sel_o
);
    typedef struct packed {
        logic fav_hi;
    } pair_st_t;

    pair_st_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (req_i == 2'b11) begin
            sel_o = s_q.fav_hi ? 2'b10 : 2'b01;
        end else begin
            sel_o = req_i;
        end
        // R4: preference moves only when this class wins
        if (take_i) begin
            s_d.fav_hi = sel_o[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    a_r4_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && (req_i == 2'b11)) |=> (s_q.fav_hi != $past(s_q.fav_hi)));
    a_r4_idle_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> $stable(s_q.fav_hi));
    a_r4_take_valid: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> $onehot(sel_o));
endmodule

// File: rtl/dram_arb_refresh_timer.sv
module dram_arb_refresh_timer #(
    parameter int CNT_W  = 16,
    parameter int MISS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_i,
    input  logic [CNT_W-1:0]  period_i,
    input  logic              clear_i,
    output logic              pend_o,
    output logic [MISS_W-1:0] miss_o,
    output logic              ovf_o
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              pend;
        logic [MISS_W-1:0] miss;
        logic              ovf;
    } tmr_st_t;

    tmr_st_t s_q, s_d;
    logic    off;
    logic    expire;

    always_comb begin
        s_d    = s_q;
        off    = (period_i == '0);
        expire = !hold_i && !off && (s_q.cnt == '0);
        // R6: reload while held or stopped, count down otherwise
        if (off) begin
            s_d.cnt = '0;
        end else if (hold_i || (s_q.cnt == '0)) begin
            s_d.cnt = period_i - 1'b1;
        end else begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
        // R7: one pending slot, lost expiries counted
        if (expire && s_q.pend && !clear_i) begin
            if (s_q.miss == '1) begin
                s_d.ovf = 1'b1;
            end else begin
                s_d.miss = s_q.miss + 1'b1;
            end
        end
        s_d.pend = expire | (s_q.pend & ~clear_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pend_o = s_q.pend;
    assign miss_o = s_q.miss;
    assign ovf_o  = s_q.ovf;

    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ovf |=> s_q.ovf);
    a_r7_ovf_full: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ovf |-> (s_q.miss == '1));
    a_r6_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.pend) |-> ($past(period_i) != '0));
endmodule

// File: rtl/dram_arbiter.sv
module dram_arbiter
    import dram_arb_pkg::*;
#(
    parameter int RCNT_W     = 16,
    parameter int MISS_W     = 4,
    parameter int AGE_PERIOD = 4096
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [10:0]         req_i,
    input  logic                done_i,
    input  logic                lan_gap_i,
    input  logic [RCNT_W-1:0]   refresh_period_i,
    output logic [10:0]         gnt_o,
    output logic [2:0]          hk_gnt_o,
    output logic                busy_o,
    output logic [MISS_W-1:0]   refresh_miss_o,
    output logic                refresh_ovf_o
);
    localparam int AGE_W = (AGE_PERIOD > 2) ? $clog2(AGE_PERIOD) : 1;
    localparam logic [AGE_W-1:0] AGE_RELOAD = AGE_W'(AGE_PERIOD - 1);

    typedef struct packed {
        logic               busy;
        logic               init_pend;
        logic [NUM_EXT-1:0] gnt;
        logic [NUM_HK-1:0]  hk;
        logic [AGE_W-1:0]   age_cnt;
        logic               age_pend;
    } arb_st_t;

    arb_st_t                    s_q, s_d;
    logic [NUM_CLS-1:0]         cls_req;
    logic [NUM_CLS-1:0]         win;
    logic                       arb_ok;
    logic                       ref_pend;
    logic [NUM_PAIR-1:0][1:0]   pair_sel;
    logic [NUM_PAIR-1:0]        pair_take;

    // class request vector in rank order (R3, R8)
    always_comb begin
        cls_req              = '0;
        cls_req[CLS_LAN_FRM] = |req_i[1:0];
        cls_req[CLS_WAN_FRM] = |req_i[3:2];
        cls_req[CLS_LAN_DA]  = req_i[4];
        cls_req[CLS_SA_MNT]  = req_i[5];
        cls_req[CLS_WAN_DA]  = req_i[6];
        cls_req[CLS_CPU_FRM] = |req_i[8:7];
        cls_req[CLS_CPU_DMA] = |req_i[10:9];
        cls_req[CLS_REFRESH] = ref_pend;
        cls_req[CLS_AGING]   = s_q.age_pend & lan_gap_i;
    end

    // fixed ranking, no aging guard on low classes (R5)
    always_comb begin
        arb_ok = !s_q.busy && !s_q.init_pend;
        win    = '0;
        for (int i = 0; i < NUM_CLS; i++) begin
            if (arb_ok && cls_req[i] && (win == '0)) begin
                win[i] = 1'b1;
            end
        end
    end

    for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
        assign pair_take[p] = win[PAIR_CLS[p]];
        dram_arb_pair u_pair (
            .clk    (clk),
            .rst_n  (rst_n),
            .req_i  (req_i[PAIR_BASE[p] +: 2]),
            .take_i (pair_take[p]),
            .sel_o  (pair_sel[p])
        );
    end

    always_comb begin
        s_d     = s_q;
        s_d.gnt = '0;
        s_d.hk  = '0;
        if (!s_q.busy && s_q.init_pend) begin
            s_d.hk[HK_INIT] = 1'b1;  // R1
            s_d.busy        = 1'b1;
        end else if (win != '0) begin
            s_d.busy = 1'b1;
            for (int p = 0; p < NUM_PAIR; p++) begin
                if (win[PAIR_CLS[p]]) begin
                    s_d.gnt[PAIR_BASE[p] +: 2] = pair_sel[p];
                end
            end
            s_d.gnt[4]         = win[CLS_LAN_DA];
            s_d.gnt[5]         = win[CLS_SA_MNT];
            s_d.gnt[6]         = win[CLS_WAN_DA];
            s_d.hk[HK_REFRESH] = win[CLS_REFRESH];
            s_d.hk[HK_AGING]   = win[CLS_AGING];
        end
        // R2, R9: done only ends an ownership that exists
        if (s_q.busy && done_i) begin
            s_d.busy      = 1'b0;
            s_d.init_pend = 1'b0;
        end
        // R8: aging interval, held during initialization
        if (s_q.init_pend || (s_q.age_cnt == '0)) begin
            s_d.age_cnt = AGE_RELOAD;
        end else begin
            s_d.age_cnt = s_q.age_cnt - 1'b1;
        end
        s_d.age_pend = (!s_q.init_pend && (s_q.age_cnt == '0))
                     | (s_q.age_pend & ~s_d.hk[HK_AGING]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q           <= '0;
            s_q.init_pend <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    dram_arb_refresh_timer #(
        .CNT_W  (RCNT_W),
        .MISS_W (MISS_W)
    ) u_refresh (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_i   (s_q.init_pend),
        .period_i (refresh_period_i),
        .clear_i  (s_d.hk[HK_REFRESH]),
        .pend_o   (ref_pend),
        .miss_o   (refresh_miss_o),
        .ovf_o    (refresh_ovf_o)
    );

    assign gnt_o    = s_q.gnt;
    assign hk_gnt_o = s_q.hk;
    assign busy_o   = s_q.busy;

    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gnt_o, hk_gnt_o}));
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (|{gnt_o, hk_gnt_o}) |=> !(|{gnt_o, hk_gnt_o}));
    a_r2_hold_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !done_i) |=> s_q.busy);
    a_r1_init_first: assert property (@(posedge clk) disable iff (!rst_n)
        (|{gnt_o, hk_gnt_o[2:1]}) |-> !s_q.init_pend);
    a_r8_age_gap: assert property (@(posedge clk) disable iff (!rst_n)
        hk_gnt_o[HK_AGING] |-> $past(lan_gap_i));
    a_r9_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.busy && !s_q.init_pend && done_i && (cls_req == '0)) |=> !s_q.busy);
endmodule

// File: tb/dram_arbiter_bench.sv
module dram_arbiter_bench;
    localparam int MW = 4;
    localparam int AP = 40;
    localparam int MISS_MAX = (1 << MW) - 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [10:0]   req;
    logic          done;
    logic          gap;
    logic [15:0]   period;
    logic [10:0]   gnt;
    logic [2:0]    hk;
    logic          busy;
    logic [MW-1:0] miss;
    logic          ovf;

    always #10 clk = ~clk;

    dram_arbiter #(.RCNT_W(16), .MISS_W(MW), .AGE_PERIOD(AP)) u_dram_arbiter (
        .clk              (clk),
        .rst_n            (rst_n),
        .req_i            (req),
        .done_i           (done),
        .lan_gap_i        (gap),
        .refresh_period_i (period),
        .gnt_o            (gnt),
        .hk_gnt_o         (hk),
        .busy_o           (busy),
        .refresh_miss_o   (miss),
        .refresh_ovf_o    (ovf)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // requirement-level model state
    logic        m_busy, m_init, m_rpend, m_ovf, m_apend;
    logic [10:0] m_gnt;
    logic [2:0]  m_hk;
    logic [3:0]  m_ptr;
    int          m_rcnt, m_miss, m_acnt;
    // requestor model
    logic        owner;
    int          hold;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int pick(input logic [1:0] r, input logic fav_hi);
        if (r == 2'b11) return fav_hi ? 1 : 0;
        return r[1] ? 1 : 0;
    endfunction

    task automatic m_reset();
        m_busy = 0; m_init = 1; m_rpend = 0; m_ovf = 0; m_apend = 0;
        m_gnt = '0; m_hk = '0; m_ptr = '0;
        m_rcnt = 0; m_miss = 0; m_acnt = 0;
    endtask

    task automatic model_next();
        int bases [4] = '{0, 2, 7, 9};
        int pcls  [4] = '{0, 1, 5, 6};
        logic [8:0]  cr;
        logic [10:0] ng;
        logic [2:0]  nh;
        logic        nb, ni, rexp, aexp;
        int          w;
        cr = {m_apend & gap, m_rpend, |req[10:9], |req[8:7], req[6], req[5], req[4],
              |req[3:2], |req[1:0]};
        ng = '0; nh = '0; nb = m_busy; ni = m_init; w = -1;
        if (!m_busy && m_init) begin
            nh[0] = 1'b1; nb = 1'b1;
        end else if (!m_busy) begin
            for (int i = 0; i < 9; i++) if (cr[i] && w < 0) w = i;
        end
        if (w >= 0) begin
            nb = 1'b1;
            for (int p = 0; p < 4; p++) begin
                if (pcls[p] == w) begin
                    int k;
                    k = pick(req[bases[p] +: 2], m_ptr[p]);
                    ng[bases[p] + k] = 1'b1;
                    m_ptr[p] = (k == 0);
                end
            end
            case (w)
                2: ng[4] = 1'b1;
                3: ng[5] = 1'b1;
                4: ng[6] = 1'b1;
                7: nh[1] = 1'b1;
                8: nh[2] = 1'b1;
                default: ;
            endcase
        end
        if (m_busy && done) begin nb = 1'b0; ni = 1'b0; end
        rexp = !m_init && (period != 0) && (m_rcnt == 0);
        if (period == 0) m_rcnt = 0;
        else if (m_init || m_rcnt == 0) m_rcnt = int'(period) - 1;
        else m_rcnt = m_rcnt - 1;
        if (rexp && m_rpend && !nh[1]) begin
            if (m_miss == MISS_MAX) m_ovf = 1'b1;
            else m_miss = m_miss + 1;
        end
        m_rpend = rexp | (m_rpend & !nh[1]);
        aexp = !m_init && (m_acnt == 0);
        if (m_init || m_acnt == 0) m_acnt = AP - 1;
        else m_acnt = m_acnt - 1;
        m_apend = aexp | (m_apend & !nh[2]);
        m_gnt = ng; m_hk = nh; m_busy = nb; m_init = ni;
    endtask

    task automatic step();
        model_next();
        @(posedge clk);
        @(negedge clk);
        chk("R3 gnt_o vs ranking", 32'(gnt), 32'(m_gnt));
        chk("R1 init grant", 32'(hk[0]), 32'(m_hk[0]));
        chk("R6 refresh grant", 32'(hk[1]), 32'(m_hk[1]));
        chk("R8 aging grant", 32'(hk[2]), 32'(m_hk[2]));
        chk("R2 busy_o", 32'(busy), 32'(m_busy));
        chk("R7 miss count", 32'(miss), 32'(m_miss));
        chk("R7 overflow", 32'(ovf), 32'(m_ovf));
    endtask

    task automatic do_reset();
        rst_n = 1'b0; done = 1'b0; owner = 1'b0; hold = 0;
        @(negedge clk);
        @(negedge clk);
        m_reset();
        chk("R2 reset gnt_o", 32'(gnt), 32'h0);
        chk("R2 reset hk_gnt_o", 32'(hk), 32'h0);
        chk("R2 reset busy_o", 32'(busy), 32'h0);
        chk("R7 reset miss", 32'(miss), 32'h0);
        rst_n = 1'b1;
    endtask

    // finish initialization: init grant, then done, then back to idle
    task automatic finish_init();
        step();
        done = 1'b1;
        step();
        done = 1'b0;
    endtask

    task automatic auto_stim(input int load);
        if ((|m_gnt) || (|m_hk)) begin
            req   = req & ~m_gnt;
            owner = 1'b1;
            hold  = int'($urandom % 4);
        end
        done = 1'b0;
        if (owner) begin
            if (hold == 0) begin done = 1'b1; owner = 1'b0; end
            else hold = hold - 1;
        end else if (!m_busy && ($urandom % 20 == 0)) begin
            done = 1'b1;  // R9 stray done while idle
        end
        for (int i = 0; i < 11; i++) begin
            if (!req[i] && ($urandom % load == 0)) req[i] = 1'b1;
        end
        gap = ($urandom % 3 == 0);
        if ($urandom % 500 == 0) period = 16'($urandom % 25);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired before the end of the run");
        summary();
        $finish;
    end

    initial begin
        int seen;
        void'($urandom(32'd1234));
        req = 11'h7FF; gap = 1'b0; period = 16'd20;

        // R1 and R3, R4, R5: all requestors busy from reset
        do_reset();
        step();
        chk("R1 init granted first", 32'(hk), 32'h1);
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R1 nothing during init", 32'(gnt), 32'h0);
        end
        done = 1'b1;
        step();
        done = 1'b0;
        chk("R2 no grant on done edge", 32'(gnt), 32'h0);
        step();
        chk("R3 LAN receive wins first", 32'(gnt), 32'h001);
        for (int k = 0; k < 30; k++) begin
            req  = 11'h7FF;
            done = 1'b1;
            step();
            done = 1'b0;
            step();
            chk("R4 LAN pair alternates", 32'(gnt), (k % 2 == 0) ? 32'h002 : 32'h001);
            chk("R5 processor held off", 32'(gnt[10:7]), 32'h0);
        end

        // R7: refresh expiries while memory stays owned
        req = '0; period = 16'd3;
        do_reset();
        finish_init();
        req = 11'h010;
        step();
        chk("R3 LAN lookup granted", 32'(gnt), 32'h010);
        req = '0;
        for (int i = 0; i < 80; i++) step();
        chk("R7 miss saturated", 32'(miss), 32'(MISS_MAX));
        chk("R7 overflow set", 32'(ovf), 32'h1);
        done = 1'b1;
        step();
        done = 1'b0;
        step();
        chk("R6 pending refresh served", 32'(hk), 32'h2);
        done = 1'b1;
        step();
        done = 1'b0;
        for (int i = 0; i < 10; i++) step();
        chk("R7 overflow sticky", 32'(ovf), 32'h1);

        // R6 period 0, R8 gap gating
        period = 16'd0; gap = 1'b0;
        do_reset();
        finish_init();
        seen = 0;
        for (int i = 0; i < 60; i++) begin
            step();
            if (hk[1] || hk[2]) seen++;
        end
        chk("R6 R8 no refresh or aging grant", 32'(seen), 32'h0);
        gap = 1'b1;
        step();
        chk("R8 aging granted in gap", 32'(hk), 32'h4);
        gap = 1'b0;
        done = 1'b1;
        step();
        done = 1'b0;
        period = 16'd10;
        seen = 0;
        for (int i = 0; i < 12; i++) begin
            step();
            if (hk[1]) seen++;
        end
        chk("R6 refresh restarts", 32'(seen), 32'h1);

        // R9: stray done while idle
        period = 16'd0;
        do_reset();
        finish_init();
        done = 1'b1;
        step();
        done = 1'b0;
        chk("R9 stray done ignored", 32'(busy), 32'h0);
        req = 11'h020;
        step();
        chk("R9 next grant on time", 32'(gnt), 32'h020);

        // random traffic against the model
        req = '0; period = 16'd17;
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            auto_stim((i < 1500) ? 3 : 12);
            step();
        end

        summary();
        $finish;
    end
endmodule